// File: doc/BRIEF.md
# Address Tenure Sequencer with Streaming

This block runs the address phase of a bus master. It takes one request at a time from a transaction queue. It waits for a qualified grant, then drives a one-cycle transfer-start pulse together with the address, the attributes and per-byte parity. It holds all of these steady until an address acknowledge closes the tenure. The data phase is handled elsewhere.

A single mode pin sets the bus behaviour. The level of the pin in the last reset cycle picks one of two modes:

- **Legacy mode:** an undriven turnaround cycle follows every tenure.
- **Extended mode:** the next tenure may begin in the cycle right after an acknowledge, so tenures stream back to back.

After reset release, in extended mode only, the pin level also selects keep-driven operation. In that operation the address enable stays on between tenures and the last address is held. A status output reports whether keep-driven operation is active.

Top module: `addr_tenure_seq`

## Requirements
- R1: The level of `mode_pin` in the last clock cycle with `rst_n` low fixes the mode until the next reset. A 1 selects extended mode and a 0 selects legacy mode.
- R2: In extended mode, `drv_status` follows `mode_pin` with one cycle of delay after reset release. A 1 means keep-driven operation and a 0 means normal driving.
- R3: In legacy mode, `drv_status` stays 0 whatever `mode_pin` does after reset, and the address enable is never held between tenures.
- R4: A tenure is accepted only when `req_valid` and `bus_grant` are 1, `bus_busy` is 0, and the block is free. In that cycle `req_pop` is 1. `ts_out` is then a single-cycle pulse in the next cycle.
- R5: An `addr_ack` in the same cycle as `ts_out` is ignored. The earliest acknowledge that counts is the cycle after transfer start.
- R6: In legacy mode, the cycle after an accepted acknowledge has `addr_oe` and `ts_out` low. Consecutive transfer starts are therefore at least 3 cycles apart: 3 plus the acknowledge delay.
- R7: In extended mode, a request that is qualified in the acknowledge cycle starts its tenure in the next cycle. With an undelayed acknowledge, transfer starts are 2 cycles apart and `addr_oe` never drops between them.
- R8: `addr_out` and `attr_out` take the request values in the `ts_out` cycle. They stay unchanged until the next transfer start.
- R9: `par_out[i]` is the even-parity bit of address byte i, meaning the XOR of `addr_out[8i+7:8i]`. It is driven together with the address.
- R10: Out of reset and in normal driving, `addr_oe` is 0 when no tenure is active. It drops in the cycle after the acknowledge unless a streamed tenure follows.
- R11: In keep-driven operation, `addr_oe` stays 1 between tenures and `addr_out` keeps the last tenure's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pin | input | 1 | Mode select: sampled in reset for the mode, after reset for keep-driven |
| req_valid | input | 1 | Queue has a pending request |
| req_addr | input | AW | Address of the pending request |
| req_attr | input | TW | Transfer attributes of the pending request |
| req_pop | output | 1 | Request accepted this cycle |
| bus_grant | input | 1 | Address bus granted to this master |
| bus_busy | input | 1 | Address bus still occupied by another tenure |
| addr_ack | input | 1 | Address acknowledge from the system |
| ts_out | output | 1 | Transfer start pulse |
| addr_out | output | AW | Driven address |
| attr_out | output | TW | Driven attributes |
| par_out | output | AW/8 | Even parity per address byte |
| addr_oe | output | 1 | Enable for the address, attribute and parity drivers |
| drv_status | output | 1 | Read-only status: keep-driven operation active |

## Verification
The outputs appear on a fixed schedule:

- `req_pop` is combinational, valid in the same cycle as the inputs that qualify the request.
- `ts_out`, `addr_out`, `attr_out` and `par_out` appear one cycle after the clock edge that accepts the request.
- `addr_oe` falls one cycle after the edge that samples the acknowledge.
- `drv_status` trails `mode_pin` by one edge.

The bench changes inputs on the falling clock edge. It reads registered outputs at the next falling edge, one register stage later, and reads `req_pop` a nanosecond after driving its inputs. Tenure spacing is measured by counting falling edges between observed transfer starts, and the acknowledge is placed a chosen number of cycles after each observed start.

// File: rtl/ats_pkg.sv
`timescale 1ns/1ps
// Shared types for the address tenure sequencer.
package ats_pkg;
    // Address-phase position of the sequencer.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // no tenure; bus may be taken
        PH_ADDR = 2'd1,  // tenure active, waiting for acknowledge
        PH_TURN = 2'd2   // legacy turnaround, bus undriven
    } phase_t;
endpackage

// File: rtl/ats_mode_latch.sv
`timescale 1ns/1ps
// Mode latch.
// Samples the mode pin on every reset cycle, so the value present in the
// last reset cycle decides extended (1) or legacy (0) mode. After reset the
// same pin selects keep-driven operation, honoured only in extended mode.
// Assumes the pin is synchronous to clk.
module ats_mode_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_pin,
    output logic ext_mode,
    output logic drv_mode
);
    logic ext_q;
    logic drv_q;

    // Capture mode during reset, then track keep-driven request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q <= mode_pin;
            drv_q <= 1'b0;
        end else begin
            drv_q <= ext_q & mode_pin;
        end
    end

    assign ext_mode = ext_q;
    assign drv_mode = drv_q;
endmodule

// File: rtl/ats_tenure_fsm.sv
`timescale 1ns/1ps
// Tenure sequencer.
// Decides when a tenure may start, pulses transfer start for one cycle and
// ends the tenure on an acknowledge taken no earlier than the cycle after
// transfer start. Legacy mode inserts a turnaround phase; extended mode may
// start the next tenure straight from the acknowledge cycle.
// Assumes bus_grant/bus_busy describe the coming cycle's ownership.
module ats_tenure_fsm
    import ats_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ext_mode,
    input  logic   req_valid,
    input  logic   bus_grant,
    input  logic   bus_busy,
    input  logic   addr_ack,
    output phase_t phase,
    output logic   ts_q,
    output logic   start
);
    phase_t phase_q;
    phase_t phase_d;
    logic   ack_ok;
    logic   slot_free;
    logic   grant_ok;

    // Qualify acknowledge and grant for this cycle.
    always_comb begin
        ack_ok    = (phase_q == PH_ADDR) && !ts_q && addr_ack;
        grant_ok  = bus_grant && !bus_busy;
        slot_free = (phase_q == PH_IDLE) || (phase_q == PH_TURN) ||
                    (ack_ok && ext_mode);
        start     = slot_free && req_valid && grant_ok;
    end

    // Next phase selection.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: if (start) phase_d = PH_ADDR;
            PH_ADDR: begin
                if (start)       phase_d = PH_ADDR;
                else if (ack_ok) phase_d = ext_mode ? PH_IDLE : PH_TURN;
            end
            PH_TURN: phase_d = start ? PH_ADDR : PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    // Phase and transfer-start registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            ts_q    <= 1'b0;
        end else begin
            phase_q <= phase_d;
            ts_q    <= start;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/ats_addr_drv.sv
`timescale 1ns/1ps
// Address driver.
// Loads address, attributes and per-byte even parity when a tenure starts
// and holds them until the next start. Derives the driver enable from the
// tenure phase and the keep-driven flag.
// Assumes AW is a multiple of 8.
module ats_addr_drv #(
    parameter int AW = 32,
    parameter int TW = 8,
    localparam int NB = AW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] req_addr,
    input  logic [TW-1:0] req_attr,
    input  logic          in_tenure,
    input  logic          hold_drv,
    output logic [AW-1:0] addr_q,
    output logic [TW-1:0] attr_q,
    output logic [NB-1:0] par_q,
    output logic          addr_oe
);
    logic [NB-1:0] par_next;

    // One even-parity bit per address byte.
    for (genvar b = 0; b < NB; b++) begin : g_par
        assign par_next[b] = ^req_addr[8*b +: 8];
    end

    // Capture the request at tenure start; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            attr_q <= '0;
            par_q  <= '0;
        end else if (load) begin
            addr_q <= req_addr;
            attr_q <= req_attr;
            par_q  <= par_next;
        end
    end

    // Drive during a tenure, or always in keep-driven operation.
    assign addr_oe = in_tenure || hold_drv;
endmodule

// File: rtl/addr_tenure_seq.sv
`timescale 1ns/1ps
// Address tenure sequencer, top level.
// Ties the mode latch, the tenure sequencer and the address driver together.
// Assumes one request is offered at a time and is removed on req_pop.
module addr_tenure_seq #(
    parameter int AW = 32,
    parameter int TW = 8,
    localparam int NB = AW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_pin,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [TW-1:0] req_attr,
    output logic          req_pop,
    input  logic          bus_grant,
    input  logic          bus_busy,
    input  logic          addr_ack,
    output logic          ts_out,
    output logic [AW-1:0] addr_out,
    output logic [TW-1:0] attr_out,
    output logic [NB-1:0] par_out,
    output logic          addr_oe,
    output logic          drv_status
);
    import ats_pkg::*;

    logic   ext_mode;
    logic   drv_mode;
    phase_t phase;
    logic   start;
    logic   in_tenure;

    ats_mode_latch u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_pin (mode_pin),
        .ext_mode (ext_mode),
        .drv_mode (drv_mode)
    );

    ats_tenure_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_mode  (ext_mode),
        .req_valid (req_valid),
        .bus_grant (bus_grant),
        .bus_busy  (bus_busy),
        .addr_ack  (addr_ack),
        .phase     (phase),
        .ts_q      (ts_out),
        .start     (start)
    );

    // A tenure occupies the bus while in the address phase.
    assign in_tenure = (phase == PH_ADDR);

    ats_addr_drv #(.AW(AW), .TW(TW)) u_drv (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .req_addr  (req_addr),
        .req_attr  (req_attr),
        .in_tenure (in_tenure),
        .hold_drv  (drv_mode),
        .addr_q    (addr_out),
        .attr_q    (attr_out),
        .par_q     (par_out),
        .addr_oe   (addr_oe)
    );

    assign req_pop    = start;
    assign drv_status = drv_mode;
endmodule

// File: rtl/ats_checker.sv
`timescale 1ns/1ps
// Protocol checker for addr_tenure_seq, attached by bind.
module ats_checker #(
    parameter int AW = 32,
    localparam int NB = AW / 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_mode,
    input logic          req_valid,
    input logic          bus_grant,
    input logic          bus_busy,
    input logic          addr_ack,
    input logic          ts_out,
    input logic [AW-1:0] addr_out,
    input logic [NB-1:0] par_out,
    input logic          addr_oe,
    input logic          drv_status
);
    p_ts_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ts_out |=> !ts_out)
        else $error("ts_out wider than one cycle");

    p_ts_qualified_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ts_out |-> $past(req_valid && bus_grant && !bus_busy))
        else $error("transfer start without qualified grant");

    p_no_drv_legacy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_mode |-> !drv_status)
        else $error("keep-driven status in legacy mode");

    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && addr_ack && addr_oe && !ts_out) |=> (!addr_oe && !ts_out))
        else $error("missing legacy turnaround");

    p_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && addr_ack && addr_oe && !ts_out && req_valid &&
         bus_grant && !bus_busy) |=> ts_out)
        else $error("streamed tenure did not start");

    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ts_out |-> $stable(addr_out))
        else $error("address moved outside transfer start");

    p_hold_oe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        drv_status |-> addr_oe)
        else $error("enable dropped in keep-driven operation");

    for (genvar b = 0; b < NB; b++) begin : g_pchk
        p_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
            addr_oe |-> (par_out[b] == ^addr_out[8*b +: 8]))
            else $error("byte parity wrong");
    end
endmodule

bind addr_tenure_seq ats_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .req_valid  (req_valid),
    .bus_grant  (bus_grant),
    .bus_busy   (bus_busy),
    .addr_ack   (addr_ack),
    .ts_out     (ts_out),
    .addr_out   (addr_out),
    .par_out    (par_out),
    .addr_oe    (addr_oe),
    .drv_status (drv_status)
);

// File: tb/sim_addr_tenure_seq.sv
`timescale 1ns/1ps
module sim_addr_tenure_seq;
    localparam int AW = 32;
    localparam int TW = 8;
    localparam int NB = AW / 8;
    localparam int NT = 4;
    localparam int ROWS = 6;
    // [15] pin at release, [14] pin after, [11:8] ack delay,
    // [7:4] expected start spacing, [0] expected keep-driven
    localparam logic [15:0] VEC [ROWS] = '{
        16'h0030,  // legacy, undelayed ack
        16'h0250,  // legacy, ack delayed by 2
        16'h8020,  // extended normal, streaming
        16'hC021,  // extended keep-driven, streaming
        16'h8130,  // extended normal, ack delayed by 1
        16'h4030   // legacy, pin raised after reset
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_pin = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [TW-1:0] req_attr = '0;
    logic          req_pop;
    logic          bus_grant = 1'b0;
    logic          bus_busy = 1'b0;
    logic          addr_ack = 1'b0;
    logic          ts_out;
    logic [AW-1:0] addr_out;
    logic [TW-1:0] attr_out;
    logic [NB-1:0] par_out;
    logic          addr_oe;
    logic          drv_status;

    int n_checks = 0;
    int n_fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    addr_tenure_seq #(.AW(AW), .TW(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_pin(mode_pin),
        .req_valid(req_valid), .req_addr(req_addr), .req_attr(req_attr),
        .req_pop(req_pop), .bus_grant(bus_grant), .bus_busy(bus_busy),
        .addr_ack(addr_ack), .ts_out(ts_out), .addr_out(addr_out),
        .attr_out(attr_out), .par_out(par_out), .addr_oe(addr_oe),
        .drv_status(drv_status)
    );

    function automatic logic [NB-1:0] even_par(input logic [AW-1:0] a);
        logic [NB-1:0] p;
        for (int b = 0; b < NB; b++) begin
            p[b] = 1'b0;
            for (int k = 0; k < 8; k++) p[b] = p[b] ^ a[8*b + k];
        end
        return p;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic m_rel, input logic m_after);
        @(negedge clk);
        rst_n = 1'b0; mode_pin = m_rel; req_valid = 1'b0;
        bus_grant = 1'b0; bus_busy = 1'b0; addr_ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        mode_pin = m_after;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_row(input int r);
        logic          m_rel;
        logic          m_after;
        int            dly;
        int            spc;
        logic          x_drv;
        logic          pend;
        int            wt;
        int            nts;
        int            last_t;
        int            gaps;
        logic [AW-1:0] cur;
        logic [AW-1:0] ten_addr;
        logic [TW-1:0] ten_attr;
        m_rel   = VEC[r][15];
        m_after = VEC[r][14];
        dly     = int'(VEC[r][11:8]);
        spc     = int'(VEC[r][7:4]);
        x_drv   = VEC[r][0];
        pend = 1'b0; wt = 0; nts = 0; last_t = 0; gaps = 0;
        ten_addr = '0; ten_attr = '0;
        do_reset(m_rel, m_after);
        cur = 32'h1000_0000 + 32'h0011_2233 * r;
        req_addr = cur; req_attr = TW'(r + 8'h40);
        bus_grant = 1'b1; req_valid = 1'b1;
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            if (ts_out) begin
                if (nts > 0)
                    chk(m_rel ? "R7 R1 start spacing" : "R6 R1 start spacing", t - last_t, spc);
                chk("R8 address at start", addr_out, cur);
                chk("R8 attributes at start", attr_out, req_attr);
                chk("R9 parity at start", par_out, even_par(cur));
                ten_addr = cur; ten_attr = req_attr;
                last_t = t; nts++; pend = 1'b1; wt = 0; addr_ack = 1'b0;
                cur = cur + 32'h0101_0F13;
                req_addr = cur; req_attr = req_attr + 1'b1;
                if (nts == NT) req_valid = 1'b0;
            end else begin
                if (nts > 0 && nts < NT && !addr_oe) gaps++;
                if (pend) begin
                    chk("R8 address held", addr_out, ten_addr);
                    chk("R8 attributes held", attr_out, ten_attr);
                    if (wt == dly) begin addr_ack = 1'b1; pend = 1'b0; end
                    else begin wt++; addr_ack = 1'b0; end
                end else begin
                    addr_ack = 1'b0;
                end
            end
        end
        chk("R4 tenures completed", nts, NT);
        chk(m_rel ? "R7 enable gaps" : "R6 enable gaps", gaps, m_rel ? 0 : NT - 1);
        chk(m_rel ? "R2 drive status" : "R3 drive status", drv_status, x_drv);
        chk(x_drv ? "R11 enable held" : "R10 enable idle", addr_oe, x_drv);
        if (x_drv) chk("R11 last address held", addr_out, ten_addr);
        bus_grant = 1'b0;
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        #2000000;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // Reset state.
        mode_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 ts in reset", ts_out, 1'b0);
        chk("R10 enable in reset", addr_oe, 1'b0);
        chk("R2 status in reset", drv_status, 1'b0);

        // Grant qualification, ignored early ack, enable release.
        do_reset(1'b1, 1'b0);
        chk("R2 normal driving status", drv_status, 1'b0);
        chk("R10 enable idle after reset", addr_oe, 1'b0);
        req_addr = 32'hA5A5_0F0F; req_attr = 8'h3C;
        req_valid = 1'b1; bus_grant = 1'b1; bus_busy = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #1 chk("R4 pop blocked by busy", req_pop, 1'b0);
            @(negedge clk);
            chk("R4 no start while busy", ts_out, 1'b0);
        end
        bus_busy = 1'b0; bus_grant = 1'b0;
        #1 chk("R4 pop blocked without grant", req_pop, 1'b0);
        @(negedge clk);
        chk("R4 no start without grant", ts_out, 1'b0);
        bus_grant = 1'b1;
        #1 chk("R4 pop on qualified grant", req_pop, 1'b1);
        @(negedge clk);
        chk("R4 start pulse", ts_out, 1'b1);
        chk("R8 address", addr_out, 32'hA5A5_0F0F);
        req_valid = 1'b0; addr_ack = 1'b1;   // ack during transfer start
        @(negedge clk);
        chk("R4 start is one cycle", ts_out, 1'b0);
        chk("R5 early ack ignored", addr_oe, 1'b1);
        @(negedge clk);
        addr_ack = 1'b0;
        chk("R10 enable drops after ack", addr_oe, 1'b0);
        chk("R4 no extra start", ts_out, 1'b0);

        // Parity pattern and keep-driven hold.
        do_reset(1'b1, 1'b1);
        chk("R2 keep-driven status", drv_status, 1'b1);
        chk("R11 enable before first tenure", addr_oe, 1'b1);
        req_addr = 32'h0103_07FF; req_attr = 8'h81;
        req_valid = 1'b1; bus_grant = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 start", ts_out, 1'b1);
        chk("R9 byte parity 1,0,1,0", par_out, 4'b1010);
        @(negedge clk);
        addr_ack = 1'b1;
        @(negedge clk);
        addr_ack = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R11 enable held", addr_oe, 1'b1);
            chk("R11 address held", addr_out, 32'h0103_07FF);
        end
        bus_grant = 1'b0;

        // Table-driven mode and spacing runs.
        for (int r = 0; r < ROWS; r++) run_row(r);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule